// File: doc/BRIEF.md
# Sixteen-bit instruction decoder

This block turns one 16-bit instruction word into the control bundle of a small CPU that has eight 16-bit registers. It splits the word into its register selectors and sorts it into an instruction class. For each class it produces the ALU operation code, the register write enables for each byte lane, the memory read and write strobes with their size and source-byte select, the bit-test flag update, the branch condition and sign-extended offset, the jump flag, and an illegal-instruction flag.

The decode logic is combinational, and a single register stage sits at the outputs, so every output shows the decode of the word that was present on the previous rising clock edge. A synchronous active-high reset clears that stage to a quiet state. The fetch stage drives `instr`. The register file, the ALU, the memory port and the program-counter logic consume the outputs.

Field layout: opcode `[15:12]`, first register `[11:9]`, mode bit `[8]`, second register `[7:5]`, third register `[4:2]`, tail `[1:0]`. Execution kinds on `ex_kind`: 0 none, 1 ALU/shift, 2 invert, 3 negate, 4 bit test-and-clear, 5 bit test-and-set, 6 move/load/store, 7 immediate byte load.

Top module: `insn_decoder`

## Requirements
- R1: `dst_sel`, `srca_sel` and `srcb_sel` carry instruction bits [11:9], [7:5] and [4:2] for every opcode.
- R2: Every output changes one clock after `instr` changes. While `rst` is high at a rising edge, the outputs clear to zero: no enables, no strobes, `ex_kind` 0 and `illegal` 0.
- R3: Opcode 0000 forms a 3-bit operation from {bit 8, bits [1:0]} and sets `alu_op` = {0, that operation}: add 0, sub 1, mul 2, div 3, and 4, or 5, xor 6. It writes both bytes with `ex_kind` 1. Operation 7 is illegal.
- R4: Opcode 0001 is a shift. Bit 8 gives the direction (1 right) and bits [1:0] give the fill mode (00 zeros, 01 ones, 10 end-bit copy, 11 rotate). `alu_op` = {1, bit 8, bits [1:0]}, both bytes are written and `ex_kind` is 1.
- R5: Opcode 0010 gives invert (bit 8 = 0, kind 2) or negate (bit 8 = 1, kind 3). Opcode 0011 gives bit test-and-clear (bit 8 = 0, kind 4) or test-and-set (bit 8 = 1, kind 5), and only this opcode raises `zf_we`. Both opcodes write both bytes and need bits [4:0] to be zero.
- R6: Opcode 0100 with bit 8 = 0 is a register move and needs bits [1:0] zero. Bit 2 set means a byte move. A byte move writes only the destination lane, chosen by bit 4 (1 high), and sets `src_hi` from bit 3. A word move writes both lanes with `src_hi` 0, whatever bits 4 and 3 hold.
- R7: Opcode 0100 with bit 8 = 1 is a memory access. With bit 0 = 1 it is a load (`mem_rd`), which writes lanes as in R6 and needs bits 3 and 1 zero. With bit 0 = 0 it is a store (`mem_wr`), which writes no register, takes `src_hi` from bit 3 for byte size and needs bits 4 and 1 zero. `mem_byte` mirrors bit 2. Read and write strobes never coincide.
- R8: Opcode 0101 loads an immediate byte, kind 7. Only the low lane is written when bit 8 = 0, and only the high lane when bit 8 = 1. `imm_data` holds bits [7:0] in every byte.
- R9: Opcode 0110 is a relative branch. It raises `br_en`, sets `br_cond` = bits [11:9] and sets `br_offset` = bits [7:0] sign-extended. Condition 110 and a set bit 8 are illegal. A branch writes no register.
- R10: Opcode 0111 is an absolute jump through the register in bits [11:9]. It raises `jump` and needs bits [8:0] zero.
- R11: Opcodes 1000 through 1111 are illegal.
- R12: An illegal word raises `illegal` and drives every write enable, `zf_we`, both memory strobes, `br_en` and `jump` to 0, with `ex_kind` 0 and `alu_op` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word to decode |
| dst_sel | output | 3 | First register field (destination / base) |
| srca_sel | output | 3 | Second register field |
| srcb_sel | output | 3 | Third register field |
| alu_op | output | 4 | ALU operation code |
| ex_kind | output | 3 | Execution kind |
| rf_we | output | 1 | Any register lane written |
| rf_we_hi | output | 1 | High-byte write enable |
| rf_we_lo | output | 1 | Low-byte write enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_byte | output | 1 | Move or memory access is byte sized |
| src_hi | output | 1 | Take the source register's high byte |
| zf_we | output | 1 | Zero flag update from bit test |
| br_en | output | 1 | Relative branch |
| br_cond | output | 3 | Branch condition code |
| br_offset | output | XLEN | Sign-extended branch offset |
| imm_data | output | XLEN | Immediate byte replicated over all lanes |
| jump | output | 1 | Absolute jump |
| illegal | output | 1 | Instruction is not defined |

## Verification
The bench aims at the places where the split operation field and the byte-lane fields go wrong. A decoder that read the ALU operation from adjacent bits would map xor or div to the wrong code. One that swapped the destination and source byte selects would write the wrong lane or pick the wrong source byte. If it honoured those selects on word moves, a word move would write only half a register. The bench also sends every reserved-bit violation it can name: load with bit 3 set, store with bit 1 set, negate with bit 0 set, branch condition 110, jump with a stray low bit, and the upper opcodes. A decoder that missed one of them would leave a write enable or strobe active on garbage. A negative branch offset checks sign extension, and a change of input checks the one-cycle latency.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int INSN_W = 16;
  localparam int OPC_W  = 4;
  localparam int RA_W   = 3;
  localparam int ALU_W  = 4;
  localparam int IMM_W  = 8;
  localparam int COND_W = 3;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_ALU  = 3'd1,
    K_NOT  = 3'd2,
    K_NEG  = 3'd3,
    K_BCLR = 3'd4,
    K_BSET = 3'd5,
    K_MOVE = 3'd6,
    K_LDI  = 3'd7
  } ex_kind_e;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [RA_W-1:0]  r0;
    logic             mode;
    logic [RA_W-1:0]  r1;
    logic [RA_W-1:0]  r2;
    logic [1:0]       tail;
  } insn_fields_t;

  typedef struct packed {
    ex_kind_e         kind;
    logic [ALU_W-1:0] alu_op;
    logic             we_hi;
    logic             we_lo;
    logic             mem_rd;
    logic             mem_wr;
    logic             mem_byte;
    logic             src_hi;
    logic             zf_we;
    logic             br_en;
    logic             jump;
    logic             illegal;
  } ctl_t;
endpackage

// File: rtl/insn_imm_ext.sv
module insn_imm_ext
  import insn_dec_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  offs_sext,
  output logic [XLEN-1:0]  imm_rep
);
  localparam int LANES = XLEN / IMM_W;
  localparam int EXT_W = XLEN - IMM_W;

  assign offs_sext = {{EXT_W{imm[IMM_W-1]}}, imm};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign imm_rep[g*IMM_W +: IMM_W] = imm;
  end
endmodule

// File: rtl/insn_class_dec.sv
module insn_class_dec
  import insn_dec_pkg::*;
(
  input  insn_fields_t f,
  output ctl_t         c
);
  localparam logic [COND_W-1:0] COND_RSVD = 3'b110;

  logic [2:0] op3;
  logic       lane_hi, src_sel, is_byte;

  assign op3     = {f.mode, f.tail};
  assign lane_hi = f.r2[2];
  assign src_sel = f.r2[1];
  assign is_byte = f.r2[0];

  always_comb begin
    c      = '0;
    c.kind = K_NONE;
    unique case (f.opc)
      4'h0: begin
        if (op3 == 3'b111) begin
          c.illegal = 1'b1;
        end else begin
          c.kind   = K_ALU;
          c.alu_op = {1'b0, op3};
          c.we_hi  = 1'b1;
          c.we_lo  = 1'b1;
        end
      end
      4'h1: begin
        c.kind   = K_ALU;
        c.alu_op = {1'b1, f.mode, f.tail};
        c.we_hi  = 1'b1;
        c.we_lo  = 1'b1;
      end
      4'h2, 4'h3: begin
        if ({f.r2, f.tail} != '0) begin
          c.illegal = 1'b1;
        end else begin
          if (f.opc[0]) begin
            c.kind  = f.mode ? K_BSET : K_BCLR;
            c.zf_we = 1'b1;
          end else begin
            c.kind = f.mode ? K_NEG : K_NOT;
          end
          c.we_hi = 1'b1;
          c.we_lo = 1'b1;
        end
      end
      4'h4: begin
        if (!f.mode) begin
          if (f.tail != 2'b00) begin
            c.illegal = 1'b1;
          end else begin
            c.kind     = K_MOVE;
            c.mem_byte = is_byte;
            c.src_hi   = is_byte & src_sel;
            c.we_hi    = !is_byte | lane_hi;
            c.we_lo    = !is_byte | !lane_hi;
          end
        end else if (f.tail[0]) begin
          if (src_sel || f.tail[1]) begin
            c.illegal = 1'b1;
          end else begin
            c.kind     = K_MOVE;
            c.mem_rd   = 1'b1;
            c.mem_byte = is_byte;
            c.we_hi    = !is_byte | lane_hi;
            c.we_lo    = !is_byte | !lane_hi;
          end
        end else begin
          if (lane_hi || f.tail[1]) begin
            c.illegal = 1'b1;
          end else begin
            c.kind     = K_MOVE;
            c.mem_wr   = 1'b1;
            c.mem_byte = is_byte;
            c.src_hi   = is_byte & src_sel;
          end
        end
      end
      4'h5: begin
        c.kind  = K_LDI;
        c.we_hi = f.mode;
        c.we_lo = !f.mode;
      end
      4'h6: begin
        if (f.mode || f.r0 == COND_RSVD) c.illegal = 1'b1;
        else                             c.br_en   = 1'b1;
      end
      4'h7: begin
        if ({f.mode, f.r1, f.r2, f.tail} != '0) c.illegal = 1'b1;
        else                                    c.jump    = 1'b1;
      end
      default: c.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/insn_ctl_reg.sv
module insn_ctl_reg
  import insn_dec_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              c_in,
  input  insn_fields_t      f_in,
  input  logic [XLEN-1:0]   offs_in,
  input  logic [XLEN-1:0]   imm_in,
  output ctl_t              c_q,
  output logic              we_any_q,
  output insn_fields_t      f_q,
  output logic [XLEN-1:0]   offs_q,
  output logic [XLEN-1:0]   imm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      c_q      <= '0;
      we_any_q <= 1'b0;
      f_q      <= '0;
      offs_q   <= '0;
      imm_q    <= '0;
    end else begin
      c_q      <= c_in;
      we_any_q <= c_in.we_hi | c_in.we_lo;
      f_q      <= f_in;
      offs_q   <= offs_in;
      imm_q    <= imm_in;
    end
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [INSN_W-1:0]     instr,
  output logic [RA_W-1:0]       dst_sel,
  output logic [RA_W-1:0]       srca_sel,
  output logic [RA_W-1:0]       srcb_sel,
  output logic [ALU_W-1:0]      alu_op,
  output logic [2:0]            ex_kind,
  output logic                  rf_we,
  output logic                  rf_we_hi,
  output logic                  rf_we_lo,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  mem_byte,
  output logic                  src_hi,
  output logic                  zf_we,
  output logic                  br_en,
  output logic [COND_W-1:0]     br_cond,
  output logic [XLEN-1:0]       br_offset,
  output logic [XLEN-1:0]       imm_data,
  output logic                  jump,
  output logic                  illegal
);
  insn_fields_t    fld, fld_q;
  ctl_t            ctl, ctl_q;
  logic [XLEN-1:0] offs_c, imm_c;
  logic            we_any;

  assign fld = insn_fields_t'(instr);

  insn_class_dec u_class (
    .f (fld),
    .c (ctl)
  );

  insn_imm_ext #(.XLEN(XLEN)) u_imm (
    .imm       (instr[IMM_W-1:0]),
    .offs_sext (offs_c),
    .imm_rep   (imm_c)
  );

  insn_ctl_reg #(.XLEN(XLEN)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .c_in     (ctl),
    .f_in     (fld),
    .offs_in  (offs_c),
    .imm_in   (imm_c),
    .c_q      (ctl_q),
    .we_any_q (we_any),
    .f_q      (fld_q),
    .offs_q   (br_offset),
    .imm_q    (imm_data)
  );

  assign dst_sel  = fld_q.r0;
  assign srca_sel = fld_q.r1;
  assign srcb_sel = fld_q.r2;
  assign br_cond  = fld_q.r0;
  assign alu_op   = ctl_q.alu_op;
  assign ex_kind  = ctl_q.kind;
  assign rf_we    = we_any;
  assign rf_we_hi = ctl_q.we_hi;
  assign rf_we_lo = ctl_q.we_lo;
  assign mem_rd   = ctl_q.mem_rd;
  assign mem_wr   = ctl_q.mem_wr;
  assign mem_byte = ctl_q.mem_byte;
  assign src_hi   = ctl_q.src_hi;
  assign zf_we    = ctl_q.zf_we;
  assign br_en    = ctl_q.br_en;
  assign jump     = ctl_q.jump;
  assign illegal  = ctl_q.illegal;
endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk #(
  parameter int XLEN = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [15:0]     instr,
  input logic [2:0]      dst_sel,
  input logic [2:0]      srca_sel,
  input logic [2:0]      srcb_sel,
  input logic [3:0]      alu_op,
  input logic [2:0]      ex_kind,
  input logic            rf_we,
  input logic            rf_we_hi,
  input logic            rf_we_lo,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            mem_byte,
  input logic            src_hi,
  input logic            zf_we,
  input logic            br_en,
  input logic [2:0]      br_cond,
  input logic [XLEN-1:0] br_offset,
  input logic [XLEN-1:0] imm_data,
  input logic            jump,
  input logic            illegal
);
  AST_ADDR_ROUTE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dst_sel == $past(instr[11:9]) && srca_sel == $past(instr[7:5])
                     && srcb_sel == $past(instr[4:2]))); // R1
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rf_we && !mem_rd && !mem_wr && !illegal && !jump && !br_en)); // R2
  AST_ALU_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[15:12] == 4'h0 && instr[8] && instr[1:0] == 2'b11))
      |-> illegal); // R3
  AST_SHIFT_CODE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[15:12] == 4'h1))
      |-> (alu_op == {1'b1, $past(instr[8]), $past(instr[1:0])})); // R4
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R7
  AST_LDI_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[15:12] == 4'h5))
      |-> ($countones({rf_we_hi, rf_we_lo}) == 1)); // R8
  AST_OFFS_SEXT: assert property (@(posedge clk) disable iff (rst)
    br_offset[XLEN-1:8] == {(XLEN-8){br_offset[7]}}); // R9
  AST_FLOW_ONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, br_en, jump})); // R9
  AST_HI_OPC_ILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr[15])) |-> illegal); // R11
  AST_ILL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rf_we_hi && !rf_we_lo && !mem_rd && !mem_wr && !br_en && !jump
                 && !zf_we && ex_kind == 3'd0)); // R12
endmodule

bind insn_decoder insn_decoder_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/insn_decoder_tb_top.sv
module insn_decoder_tb_top;
  localparam int XLEN  = 16;
  localparam int NVEC  = 32;
  localparam int WDOG  = 20000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [15:0]     instr = 16'h0000;
  logic [2:0]      dst_sel, srca_sel, srcb_sel, ex_kind, br_cond;
  logic [3:0]      alu_op;
  logic            rf_we, rf_we_hi, rf_we_lo, mem_rd, mem_wr, mem_byte;
  logic            src_hi, zf_we, br_en, jump, illegal;
  logic [XLEN-1:0] br_offset, imm_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  insn_decoder #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .instr(instr),
    .dst_sel(dst_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
    .alu_op(alu_op), .ex_kind(ex_kind), .rf_we(rf_we),
    .rf_we_hi(rf_we_hi), .rf_we_lo(rf_we_lo), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_byte(mem_byte), .src_hi(src_hi), .zf_we(zf_we), .br_en(br_en),
    .br_cond(br_cond), .br_offset(br_offset), .imm_data(imm_data),
    .jump(jump), .illegal(illegal)
  );

  // {req, instr, kind, alu_op, we_hi we_lo rd wr byte src_hi zf br jmp ill}
  localparam logic [36:0] VEC [NVEC] = '{
    {4'd3,  16'h0628, 3'd1, 4'h0, 10'b1100000000},  // R3 add
    {4'd3,  16'h0629, 3'd1, 4'h1, 10'b1100000000},  // R3 sub
    {4'd3,  16'h062B, 3'd1, 4'h3, 10'b1100000000},  // R3 div
    {4'd3,  16'h072A, 3'd1, 4'h6, 10'b1100000000},  // R3 xor
    {4'd3,  16'h072B, 3'd0, 4'h0, 10'b0000000001},  // R3 undefined op
    {4'd4,  16'h1597, 3'd1, 4'hF, 10'b1100000000},  // R4 right rotate
    {4'd4,  16'h1495, 3'd1, 4'h9, 10'b1100000000},  // R4 left ones
    {4'd5,  16'h22C0, 3'd2, 4'h0, 10'b1100000000},  // R5 invert
    {4'd5,  16'h23C0, 3'd3, 4'h0, 10'b1100000000},  // R5 negate
    {4'd5,  16'h23C1, 3'd0, 4'h0, 10'b0000000001},  // R5 reserved bit
    {4'd5,  16'h3B40, 3'd5, 4'h0, 10'b1100001000},  // R5 test-and-set
    {4'd5,  16'h3A40, 3'd4, 4'h0, 10'b1100001000},  // R5 test-and-clear
    {4'd6,  16'h4240, 3'd6, 4'h0, 10'b1100000000},  // R6 word move
    {4'd6,  16'h4254, 3'd6, 4'h0, 10'b1000100000},  // R6 byte to high
    {4'd6,  16'h424C, 3'd6, 4'h0, 10'b0100110000},  // R6 high to low
    {4'd6,  16'h4258, 3'd6, 4'h0, 10'b1100000000},  // R6 selects ignored
    {4'd7,  16'h4340, 3'd6, 4'h0, 10'b0001000000},  // R7 store word
    {4'd7,  16'h434C, 3'd6, 4'h0, 10'b0001110000},  // R7 store high byte
    {4'd7,  16'h4355, 3'd6, 4'h0, 10'b1010100000},  // R7 load byte high
    {4'd7,  16'h4341, 3'd6, 4'h0, 10'b1110000000},  // R7 load word
    {4'd7,  16'h4349, 3'd0, 4'h0, 10'b0000000001},  // R7 load bit3 set
    {4'd7,  16'h4342, 3'd0, 4'h0, 10'b0000000001},  // R7 store bit1 set
    {4'd8,  16'h5EA5, 3'd7, 4'h0, 10'b0100000000},  // R8 low byte
    {4'd8,  16'h5FA5, 3'd7, 4'h0, 10'b1000000000},  // R8 high byte
    {4'd9,  16'h64F0, 3'd0, 4'h0, 10'b0000000100},  // R9 branch
    {4'd9,  16'h6C10, 3'd0, 4'h0, 10'b0000000001},  // R9 cond 110
    {4'd9,  16'h6510, 3'd0, 4'h0, 10'b0000000001},  // R9 bit8 set
    {4'd10, 16'h7600, 3'd0, 4'h0, 10'b0000000010},  // R10 jump
    {4'd10, 16'h7601, 3'd0, 4'h0, 10'b0000000001},  // R10 stray bit
    {4'd11, 16'h8000, 3'd0, 4'h0, 10'b0000000001},  // R11
    {4'd11, 16'hF628, 3'd0, 4'h0, 10'b0000000001},  // R11
    {4'd11, 16'hA5A5, 3'd0, 4'h0, 10'b0000000001}   // R11
  };

  function automatic logic [16:0] observed();
    return {ex_kind, alu_op, rf_we_hi, rf_we_lo, mem_rd, mem_wr, mem_byte,
            src_hi, zf_we, br_en, jump, illegal};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w);
    @(negedge clk);
    instr = w;
    @(negedge clk);
  endtask

  initial begin : wdog
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 reset", {15'd0, observed()}, 32'd0);
    check("R2 reset rf_we", {31'd0, rf_we}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][32:17]);
      n_chk++;
      if (observed() !== VEC[i][16:0]) begin
        n_bad++;
        $display("FAIL R%0d instr %h: actual %h expected %h",
                 VEC[i][36:33], VEC[i][32:17], observed(), VEC[i][16:0]);
      end
    end

    // R1 register field routing
    apply(16'h0628);
    check("R1 dst", {29'd0, dst_sel}, 32'd3);
    check("R1 srca", {29'd0, srca_sel}, 32'd1);
    check("R1 srcb", {29'd0, srcb_sel}, 32'd2);
    check("R3 rf_we", {31'd0, rf_we}, 32'd1);

    // R2 one-cycle latency: just after the input changes, the old decode stays
    @(negedge clk);
    instr = 16'h5EA5;
    #2;
    check("R2 latency hold", {29'd0, ex_kind}, 32'd1);
    @(negedge clk);
    check("R2 latency update", {29'd0, ex_kind}, 32'd7);
    check("R8 imm_data", {16'd0, imm_data}, 32'h0000A5A5);

    // R9 negative and positive offsets
    apply(16'h64F0);
    check("R9 offset neg", {16'd0, br_offset}, 32'h0000FFF0);
    check("R9 cond", {29'd0, br_cond}, 32'd2);
    check("R9 no write", {31'd0, rf_we}, 32'd0);
    apply(16'h647F);
    check("R9 offset pos", {16'd0, br_offset}, 32'h0000007F);

    // R10 jump register
    apply(16'h7600);
    check("R10 target reg", {29'd0, dst_sel}, 32'd3);

    // R6 byte move lane
    apply(16'h4254);
    check("R6 rf_we", {31'd0, rf_we}, 32'd1);

    // R12 illegal suppresses writes
    apply(16'h072B);
    check("R12 rf_we", {31'd0, rf_we}, 32'd0);

    // R2 reset in mid-run clears a pending decode
    @(negedge clk);
    instr = 16'h0628;
    rst   = 1'b1;
    @(negedge clk);
    check("R2 mid reset", {15'd0, observed()}, 32'd0);
    rst   = 1'b0;
    instr = 16'h0000;
    @(negedge clk);
    check("R3 after reset", {29'd0, ex_kind}, 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule